// File: doc/BRIEF.md
# Exception and Interrupt Dispatch Unit

This block decides which trap a processor core takes next and prepares the handler entry. It watches four fault flags: a general-protection fault and a page fault, each from either the instruction fetch path or the data access path. It also watches one external interrupt line from an I/O device. When the unit is idle it picks one winner by fixed priority and records that winner's vector number. It then runs two steps in order with the core's memory sequencer. First it asks for the return state to be pushed, over a request/done pair. Then it presents the descriptor-table entry address as a valid/ready request.

After the descriptor request is accepted, the unit stays busy until the core signals that the return-from-interrupt instruction has completed. That instruction restores the instruction pointer, code segment and flags. While the unit is busy, no other trap is dispatched. Faults that arrive during that time are dropped. An external interrupt stays pending until it is accepted.

Faults are taken in the cycle they are seen. The external interrupt is taken only at an instruction boundary, and only when no fault is present in the same cycle. The entry address is the table base plus eight bytes per vector. The table base is a fixed linear address set by a parameter and is never limit-checked.

On the descriptor request, `fetch_addr` is meaningful only while `fetch_valid` is high. Once `fetch_valid` is raised, it and `fetch_addr` stay unchanged until a cycle in which `fetch_ready` is high. That cycle completes the transfer. The push step works the same way: `push_req` stays high until a cycle in which `push_done` is high.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, `busy`, `push_req` and `fetch_valid` are low and no external interrupt is pending.
- R2: A general-protection flag from either the fetch or the data source, seen while idle, starts a dispatch with vector 13 one cycle later, whatever the state of `insn_boundary`.
- R3: A page-fault flag from either source, seen while idle with no general-protection flag, starts a dispatch with vector 14.
- R4: When general-protection and page-fault flags are raised in the same cycle, the vector is 13.
- R5: `fetch_addr` equals IDT_BASE + 8 × vector (default base 0x0000_1000). It stays stable with `fetch_valid` until `fetch_ready` is high.
- R6: A dispatch raises `push_req` in the cycle after the trap is accepted and holds it until `push_done`. `fetch_valid` follows in the next cycle. `push_req` and `fetch_valid` are never high together.
- R7: A pulse on `ext_irq` makes an interrupt pending. It is dispatched with vector 32 only in a cycle where the unit is idle and `insn_boundary` is high.
- R8: When a fault and an accepted-eligible pending interrupt meet in one cycle, the fault is dispatched. The interrupt stays pending and is dispatched after the handler returns.
- R9: While `busy` is high, new fault flags and interrupt pulses start no dispatch and leave `vector` unchanged. Faults seen then are dropped. An interrupt seen then stays pending.
- R10: `iret_done` in the active-handler state (busy, neither request high) makes `busy` low in the next cycle. `iret_done` at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gp_fetch | input | 1 | General-protection fault from instruction fetch |
| gp_data | input | 1 | General-protection fault from data access |
| pf_fetch | input | 1 | Page fault from instruction fetch |
| pf_data | input | 1 | Page fault from data access |
| ext_irq | input | 1 | External interrupt request pulse |
| insn_boundary | input | 1 | High in a cycle that lies between two instructions |
| iret_done | input | 1 | Return-from-interrupt instruction completed |
| push_req | output | 1 | Request to push the return state |
| push_done | input | 1 | Push step complete |
| fetch_valid | output | 1 | Descriptor fetch request valid |
| fetch_ready | input | 1 | Descriptor fetch request accepted |
| fetch_addr | output | 32 | Linear address of the descriptor entry |
| vector | output | 8 | Vector number of the trap being serviced |
| busy | output | 1 | A trap is being dispatched or its handler is active |

## Verification
Two pairs of events can land in the same clock cycle.

The first pair is a fault and an eligible pending interrupt. The bench provokes it by pulsing `ext_irq` and then, in a single cycle, raising both `insn_boundary` and a page-fault flag. It judges the outcome by the vector: 14 must be taken. After the return, vector 32 must follow, with no new interrupt pulse.

The second pair is the two fault kinds from different sources raised together. Only vector 13 may result.

A third case checks that `iret_done` arriving during the push step leaves the dispatch untouched.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PUSH   = 2'd1,
    ST_FETCH  = 2'd2,
    ST_ACTIVE = 2'd3
  } disp_st_e;
endpackage

// File: rtl/exc_irq_latch.sv
`timescale 1ns/1ps
// Holds an external request until the dispatcher accepts it.
module exc_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic accept,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= (pending & ~accept) | irq_in;
  end
endmodule

// File: rtl/exc_select.sv
`timescale 1ns/1ps
// Fixed-priority choice: general protection, then page fault, then interrupt.
module exc_select #(
  parameter int              N_SRC   = 2,
  parameter int              VEC_W   = 8,
  parameter logic [VEC_W-1:0] GP_VEC  = 13,
  parameter logic [VEC_W-1:0] PF_VEC  = 14,
  parameter logic [VEC_W-1:0] IRQ_VEC = 32
) (
  input  logic [N_SRC-1:0] gp_src,
  input  logic [N_SRC-1:0] pf_src,
  input  logic             idle,
  input  logic             irq_pending,
  input  logic             boundary,
  output logic             take,
  output logic             irq_accept,
  output logic [VEC_W-1:0] vec
);
  logic [N_SRC:0] gp_chain;
  logic [N_SRC:0] pf_chain;

  assign gp_chain[0] = 1'b0;
  assign pf_chain[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < N_SRC; i++) begin : g_src
      assign gp_chain[i+1] = gp_chain[i] | gp_src[i];
      assign pf_chain[i+1] = pf_chain[i] | pf_src[i];
    end
  endgenerate

  logic any_gp, any_pf, any_fault;
  assign any_gp    = gp_chain[N_SRC];
  assign any_pf    = pf_chain[N_SRC];
  assign any_fault = any_gp | any_pf;

  assign irq_accept = idle & ~any_fault & irq_pending & boundary;
  assign take       = (idle & any_fault) | irq_accept;

  always_comb begin
    if (any_gp)      vec = GP_VEC;
    else if (any_pf) vec = PF_VEC;
    else             vec = IRQ_VEC;
  end
endmodule

// File: rtl/exc_desc_addr.sv
`timescale 1ns/1ps
// Entry address = base + vector scaled by the entry size.
module exc_desc_addr #(
  parameter int                ADDR_W     = 32,
  parameter int                VEC_W      = 8,
  parameter int                ENTRY_LOG2 = 3,
  parameter logic [ADDR_W-1:0] IDT_BASE   = 32'h0000_1000
) (
  input  logic [VEC_W-1:0]  vec,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD_W = ADDR_W - VEC_W;
  logic [ADDR_W-1:0] vec_ext;
  assign vec_ext = {{PAD_W{1'b0}}, vec};
  assign addr    = IDT_BASE + (vec_ext << ENTRY_LOG2);
endmodule

// File: rtl/exc_seq.sv
`timescale 1ns/1ps
// Dispatch sequence: push state, fetch descriptor, wait for return.
module exc_seq
  import exc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take,
  input  logic     push_done,
  input  logic     fetch_ready,
  input  logic     iret_done,
  output disp_st_e state
);
  disp_st_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (take)        nxt = ST_PUSH;
      ST_PUSH:   if (push_done)   nxt = ST_FETCH;
      ST_FETCH:  if (fetch_ready) nxt = ST_ACTIVE;
      ST_ACTIVE: if (iret_done)   nxt = ST_IDLE;
      default:                    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/exc_dispatch.sv
`timescale 1ns/1ps
module exc_dispatch
  import exc_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                VEC_W      = 8,
  parameter int                ENTRY_LOG2 = 3,
  parameter logic [ADDR_W-1:0] IDT_BASE   = 32'h0000_1000,
  parameter logic [VEC_W-1:0]  GP_VEC     = 13,
  parameter logic [VEC_W-1:0]  PF_VEC     = 14,
  parameter logic [VEC_W-1:0]  IRQ_VEC    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gp_fetch,
  input  logic              gp_data,
  input  logic              pf_fetch,
  input  logic              pf_data,
  input  logic              ext_irq,
  input  logic              insn_boundary,
  input  logic              iret_done,
  output logic              push_req,
  input  logic              push_done,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [VEC_W-1:0]  vector,
  output logic              busy
);
  localparam int N_SRC = 2;

  disp_st_e          state;
  logic              idle, take, irq_accept, irq_pending;
  logic [VEC_W-1:0]  sel_vec;
  logic [VEC_W-1:0]  vec_q;

  assign idle = (state == ST_IDLE);

  exc_irq_latch u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (ext_irq),
    .accept  (irq_accept),
    .pending (irq_pending)
  );

  exc_select #(
    .N_SRC(N_SRC), .VEC_W(VEC_W),
    .GP_VEC(GP_VEC), .PF_VEC(PF_VEC), .IRQ_VEC(IRQ_VEC)
  ) u_sel (
    .gp_src      ({gp_data, gp_fetch}),
    .pf_src      ({pf_data, pf_fetch}),
    .idle        (idle),
    .irq_pending (irq_pending),
    .boundary    (insn_boundary),
    .take        (take),
    .irq_accept  (irq_accept),
    .vec         (sel_vec)
  );

  exc_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .push_done   (push_done),
    .fetch_ready (fetch_ready),
    .iret_done   (iret_done),
    .state       (state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    vec_q <= '0;
    else if (take) vec_q <= sel_vec;
  end

  exc_desc_addr #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W),
    .ENTRY_LOG2(ENTRY_LOG2), .IDT_BASE(IDT_BASE)
  ) u_addr (
    .vec  (vec_q),
    .addr (fetch_addr)
  );

  assign vector      = vec_q;
  assign push_req    = (state == ST_PUSH);
  assign fetch_valid = (state == ST_FETCH);
  assign busy        = ~idle;
endmodule

// File: rtl/exc_dispatch_chk.sv
`timescale 1ns/1ps
module exc_dispatch_chk #(
  parameter int               ADDR_W  = 32,
  parameter int               VEC_W   = 8,
  parameter logic [VEC_W-1:0] GP_VEC  = 13,
  parameter logic [VEC_W-1:0] PF_VEC  = 14,
  parameter logic [VEC_W-1:0] IRQ_VEC = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gp_fetch,
  input logic              gp_data,
  input logic              pf_fetch,
  input logic              pf_data,
  input logic              insn_boundary,
  input logic              iret_done,
  input logic              push_req,
  input logic              push_done,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [VEC_W-1:0]  vector,
  input logic              busy
);
  // R6
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({push_req, fetch_valid}) <= 1);

  // R6
  push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && !push_done |=> push_req);

  // R6
  push_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && push_done |=> fetch_valid);

  // R5
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr));

  // R4
  gp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && $past(gp_fetch || gp_data) |-> vector == GP_VEC);

  // R3
  pf_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && $past(!gp_fetch && !gp_data && (pf_fetch || pf_data))
    |-> vector == PF_VEC);

  // R7
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && $past(!gp_fetch && !gp_data && !pf_fetch && !pf_data)
    |-> vector == IRQ_VEC && $past(insn_boundary));

  // R9
  vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(vector));

  // R10
  iret_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !push_req && !fetch_valid && iret_done |=> !busy);
endmodule

bind exc_dispatch exc_dispatch_chk #(
  .ADDR_W(ADDR_W), .VEC_W(VEC_W),
  .GP_VEC(GP_VEC), .PF_VEC(PF_VEC), .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .gp_fetch(gp_fetch), .gp_data(gp_data),
  .pf_fetch(pf_fetch), .pf_data(pf_data),
  .insn_boundary(insn_boundary), .iret_done(iret_done),
  .push_req(push_req), .push_done(push_done),
  .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .fetch_addr(fetch_addr), .vector(vector), .busy(busy)
);

// File: tb/sim_exc_dispatch.sv
`timescale 1ns/1ps
module sim_exc_dispatch;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gp_fetch = 0, gp_data = 0, pf_fetch = 0, pf_data = 0;
  logic ext_irq = 0, insn_boundary = 0, iret_done = 0;
  logic push_done = 0, fetch_ready = 0;
  logic push_req, fetch_valid, busy;
  logic [31:0] fetch_addr;
  logic [7:0]  vector;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  exc_dispatch u0 (
    .clk(clk), .rst_n(rst_n),
    .gp_fetch(gp_fetch), .gp_data(gp_data),
    .pf_fetch(pf_fetch), .pf_data(pf_data),
    .ext_irq(ext_irq), .insn_boundary(insn_boundary),
    .iret_done(iret_done),
    .push_req(push_req), .push_done(push_done),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .vector(vector), .busy(busy)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_faults();
    gp_fetch = 0; gp_data = 0; pf_fetch = 0; pf_data = 0;
  endtask

  // Called one negedge after the trap was accepted; ends in the active state.
  task automatic enter(input logic [7:0] ev, input string req);
    chk(busy == 1'b1, req, busy, 1);
    chk(vector == ev, req, vector, ev);
    chk(push_req == 1'b1 && fetch_valid == 1'b0, "R6", push_req, 1);
    cyc();
    chk(push_req == 1'b1, "R6", push_req, 1);
    push_done = 1; cyc(); push_done = 0;
    chk(fetch_valid == 1'b1 && push_req == 1'b0, "R6", fetch_valid, 1);
    chk(fetch_addr == BASE + {24'd0, ev} * 8, "R5", fetch_addr, BASE + {24'd0, ev} * 8);
    cyc();
    chk(fetch_valid == 1'b1 && fetch_addr == BASE + {24'd0, ev} * 8, "R5",
        fetch_addr, BASE + {24'd0, ev} * 8);
    fetch_ready = 1; cyc(); fetch_ready = 0;
    chk(busy == 1'b1 && !fetch_valid && !push_req, "R6", busy, 1);
  endtask

  task automatic leave();
    iret_done = 1; cyc(); iret_done = 0;
    chk(busy == 1'b0, "R10", busy, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0 && push_req == 0 && fetch_valid == 0, "R1",
        {busy, push_req, fetch_valid}, 0);
    insn_boundary = 1; cyc(); insn_boundary = 0;
    chk(busy == 0, "R1", busy, 0);
  endtask

  task automatic t_gp();
    gp_fetch = 1; cyc(); clear_faults();
    enter(8'd13, "R2"); leave();
    gp_data = 1; cyc(); clear_faults();
    enter(8'd13, "R2"); leave();
  endtask

  task automatic t_pf();
    pf_fetch = 1; cyc(); clear_faults();
    enter(8'd14, "R3"); leave();
    pf_data = 1; cyc(); clear_faults();
    enter(8'd14, "R3"); leave();
  endtask

  task automatic t_both();
    gp_data = 1; pf_fetch = 1; cyc(); clear_faults();
    enter(8'd13, "R4"); leave();
    gp_fetch = 1; pf_data = 1; cyc(); clear_faults();
    enter(8'd13, "R4"); leave();
  endtask

  task automatic t_irq();
    ext_irq = 1; cyc(); ext_irq = 0;
    cyc(); cyc();
    chk(busy == 0, "R7", busy, 0);
    insn_boundary = 1; cyc(); insn_boundary = 0;
    enter(8'd32, "R7"); leave();
    insn_boundary = 1; cyc(); insn_boundary = 0;
    chk(busy == 0, "R7", busy, 0);
  endtask

  task automatic t_race();
    ext_irq = 1; cyc(); ext_irq = 0;
    insn_boundary = 1; pf_data = 1; cyc(); clear_faults(); insn_boundary = 0;
    enter(8'd14, "R8"); leave();
    insn_boundary = 1; cyc(); insn_boundary = 0;
    enter(8'd32, "R8"); leave();
  endtask

  task automatic t_busy();
    gp_data = 1; cyc(); clear_faults();
    pf_data = 1; ext_irq = 1; cyc(); clear_faults(); ext_irq = 0;
    chk(vector == 8'd13 && push_req == 1, "R9", vector, 13);
    push_done = 1; cyc(); push_done = 0;
    fetch_ready = 1; cyc(); fetch_ready = 0;
    gp_fetch = 1; insn_boundary = 1; cyc(); clear_faults(); insn_boundary = 0;
    chk(vector == 8'd13 && busy == 1, "R9", vector, 13);
    leave();
    cyc();
    chk(busy == 0, "R9", busy, 0);
    insn_boundary = 1; cyc(); insn_boundary = 0;
    enter(8'd32, "R9"); leave();
  endtask

  task automatic t_iret_ignored();
    iret_done = 1; cyc(); iret_done = 0;
    chk(busy == 0, "R10", busy, 0);
    pf_fetch = 1; cyc(); clear_faults();
    iret_done = 1; cyc(); iret_done = 0;
    chk(busy == 1 && push_req == 1, "R10", push_req, 1);
    push_done = 1; cyc(); push_done = 0;
    iret_done = 1; cyc(); iret_done = 0;
    chk(fetch_valid == 1 && vector == 8'd14, "R10", fetch_valid, 1);
    fetch_ready = 1; cyc(); fetch_ready = 0;
    leave();
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_gp();
    t_pf();
    t_both();
    t_irq();
    t_race();
    t_busy();
    t_iret_ignored();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule